// File: doc/BRIEF.md
# Outstanding Miss Entry File

This block holds a fixed pool of entries, one per cache miss still waiting for memory. A miss claims a free entry, which records the block address, a secure flag, the thread that raised the miss and the earliest time the request may go out. Each held entry is either waiting to be issued or in service, meaning it has been sent out and the response has not yet returned. The cache looks up an incoming block address to decide whether a new miss can merge with a live one. It asks the block which waiting entry to send next, marks that entry in service, and later frees it or returns it to the waiting set.

The issue choice is made by ready time, with older waiting entries winning ties. One waiting entry at a time may be forced to the front. A per-thread squash drops the waiting entries of a thread and keeps its in-service ones. A drain request reports completion once the pool is empty. At most one command takes effect per cycle. Misuse sets a sticky error flag and leaves the state as it was.

Top module: `mshr_file`

## Requirements
- R1: The pool has NUM_ENTRIES + NUM_RESERVE - 1 physical entries (4 by default). `alloc_count_o` gives the number held, `full_o` is 1 when all are held, and `empty_o` is 1 when none are held.
- R2: An allocation takes the most recently freed entry, and `alloc_idx_o` shows that index before the allocating edge. If several entries were freed in the same cycle, the lowest index among them is taken. After reset the free entries are taken in increasing index order.
- R3: A lookup hits an entry only when both the stored address and the stored secure flag equal the query. `lookup_vec_o` has bit i set for every matching held entry. `lookup_idx_o` gives the lowest matching index. `lookup_wait_hit_o` reports a match among waiting entries only.
- R4: An entry is eligible when it is waiting and its ready time is not later than `now_i`. `issue_idx_o` gives the eligible entry with the smallest ready time, and on equal ready times the one that joined the waiting set earlier.
- R5: Marking a waiting entry in service removes it from the issue choice and raises `svc_count_o` by one. The entry still counts as held.
- R6: Returning an in-service entry to pending lowers `svc_count_o` by one. The entry rejoins the waiting set as its newest member.
- R7: A front request on a waiting entry makes it the issue choice whatever its ready time, and the latest such request wins. The mark clears when the entry leaves the waiting set. A front request on an in-service entry has no effect.
- R8: Freeing a held entry lowers `alloc_count_o` by one, and also lowers `svc_count_o` if the entry was in service.
- R9: A squash frees every waiting entry whose thread equals `squash_tid_i`. In-service entries of that thread stay held.
- R10: A drain request while the pool is empty raises `drain_done_o` for one cycle after the request edge. Otherwise the request is remembered, and `drain_done_o` pulses in the cycle after the command that frees the last held entry.
- R11: The following set `err_o`, which stays set until reset, and change no state: allocating while full, freeing a free entry, marking a non-waiting entry in service, returning a non-in-service entry to pending, and a front request on a free entry.
- R12: One command is applied per cycle, in this priority order: squash, free, in-service, pending, front, allocate. Lower-priority requests in the same cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| now_i | input | TIME_W | Current time for eligibility |
| alloc_valid_i | input | 1 | Allocate request |
| alloc_addr_i | input | ADDR_W | Block address to record |
| alloc_secure_i | input | 1 | Secure flag to record |
| alloc_tid_i | input | TID_W | Thread to record |
| alloc_ready_i | input | TIME_W | Ready time to record |
| alloc_idx_o | output | IDX_W | Entry the next allocation takes |
| lookup_addr_i | input | ADDR_W | Lookup block address |
| lookup_secure_i | input | 1 | Lookup secure flag |
| lookup_hit_o | output | 1 | Some held entry matches |
| lookup_idx_o | output | IDX_W | Lowest matching index |
| lookup_vec_o | output | PHYS | All matching entries |
| lookup_wait_hit_o | output | 1 | Some waiting entry matches |
| issue_valid_o | output | 1 | An entry is ready to issue |
| issue_idx_o | output | IDX_W | Entry to issue next |
| svc_valid_i | input | 1 | Mark entry in service |
| svc_idx_i | input | IDX_W | Entry for in-service command |
| pend_valid_i | input | 1 | Return entry to pending |
| pend_idx_i | input | IDX_W | Entry for pending command |
| front_valid_i | input | 1 | Force entry to front |
| front_idx_i | input | IDX_W | Entry for front command |
| free_valid_i | input | 1 | Free an entry |
| free_idx_i | input | IDX_W | Entry to free |
| squash_valid_i | input | 1 | Squash a thread |
| squash_tid_i | input | TID_W | Thread to squash |
| drain_req_i | input | 1 | Drain request |
| drain_done_o | output | 1 | Drain complete pulse |
| full_o | output | 1 | No free entry |
| empty_o | output | 1 | No held entry |
| alloc_count_o | output | CNT_W | Held entries |
| svc_count_o | output | CNT_W | In-service entries |
| err_o | output | 1 | Sticky misuse flag |

## Verification
On every cycle, assertions check that both counters agree with the per-entry states, that the issue pick and the next free pick always name an entry in the correct state, and that at most one entry wins the ready-time race. They also check that a front mark never outlives its entry's waiting state, that a drain only completes with the pool empty, and that a squash never touches the in-service count. Only the bench scenarios can show the actual orderings: reuse of the most recently freed slot, tie-breaking after a return to pending, front override against a later ready time, and the cycle in which the drain pulse arrives.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [1:0] {
    ENT_FREE = 2'd0,
    ENT_WAIT = 2'd1,
    ENT_SVC  = 2'd2
  } ent_state_e;

  typedef enum logic [2:0] {
    CMD_NONE   = 3'd0,
    CMD_SQUASH = 3'd1,
    CMD_FREE   = 3'd2,
    CMD_SVC    = 3'd3,
    CMD_PEND   = 3'd4,
    CMD_FRONT  = 3'd5,
    CMD_ALLOC  = 3'd6
  } cmd_e;
endpackage

// File: rtl/mshr_free_pick.sv
module mshr_free_pick #(
  parameter int PHYS  = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PHYS-1:0]  free_vec_i,
  input  logic [PHYS-1:0]  freed_vec_i,
  output logic             pick_v_o,
  output logic [IDX_W-1:0] pick_idx_o
);
  localparam int RW = $clog2(PHYS) + 2;
  localparam logic [RW-1:0] RMAX = '1;

  // rank 0 = most recently freed
  logic [RW-1:0] rank_q [PHYS];
  logic [RW-1:0] best;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PHYS; i++) rank_q[i] <= RW'(i);
    end else if (|freed_vec_i) begin
      for (int i = 0; i < PHYS; i++) begin
        if (freed_vec_i[i]) rank_q[i] <= '0;
        else if (free_vec_i[i] && rank_q[i] != RMAX) rank_q[i] <= rank_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    pick_v_o   = 1'b0;
    pick_idx_o = '0;
    best       = RMAX;
    for (int i = 0; i < PHYS; i++) begin
      if (free_vec_i[i] && (!pick_v_o || rank_q[i] < best)) begin
        pick_v_o   = 1'b1;
        pick_idx_o = IDX_W'(i);
        best       = rank_q[i];
      end
    end
  end

  AST_PICK_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pick_v_o |-> free_vec_i[pick_idx_o]); // R2
endmodule

// File: rtl/mshr_issue_sel.sv
module mshr_issue_sel #(
  parameter int PHYS   = 4,
  parameter int IDX_W  = 2,
  parameter int TIME_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] now_i,
  input  logic [PHYS-1:0]   wait_vec_i,
  input  logic [TIME_W-1:0] rt_i [PHYS],
  input  logic [PHYS-1:0]   ins_vec_i,
  input  logic [PHYS-1:0]   leave_vec_i,
  input  logic              front_set_i,
  input  logic [IDX_W-1:0]  front_idx_i,
  output logic              issue_v_o,
  output logic [IDX_W-1:0]  issue_idx_o
);
  // older_q[i][j]: i joined the waiting set before j
  logic [PHYS-1:0]  older_q [PHYS];
  logic             front_v_q;
  logic [IDX_W-1:0] front_idx_q;
  logic [PHYS-1:0]  elig, win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PHYS; i++) older_q[i] <= '0;
    end else begin
      for (int k = 0; k < PHYS; k++) begin
        if (ins_vec_i[k]) begin
          older_q[k] <= '0;
          for (int j = 0; j < PHYS; j++) begin
            if (j != k) older_q[j][k] <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      front_v_q   <= 1'b0;
      front_idx_q <= '0;
    end else if (front_set_i) begin
      front_v_q   <= 1'b1;
      front_idx_q <= front_idx_i;
    end else if (front_v_q && leave_vec_i[front_idx_q]) begin
      front_v_q   <= 1'b0;
    end
  end

  always_comb begin
    for (int i = 0; i < PHYS; i++) elig[i] = wait_vec_i[i] && (rt_i[i] <= now_i);
    for (int i = 0; i < PHYS; i++) begin
      win[i] = elig[i];
      for (int j = 0; j < PHYS; j++) begin
        if (j != i && elig[j]) begin
          if (!((rt_i[i] < rt_i[j]) || (rt_i[i] == rt_i[j] && older_q[i][j])))
            win[i] = 1'b0;
        end
      end
    end
  end

  always_comb begin
    issue_v_o   = 1'b0;
    issue_idx_o = '0;
    if (front_v_q && wait_vec_i[front_idx_q]) begin
      issue_v_o   = 1'b1;
      issue_idx_o = front_idx_q;
    end else begin
      for (int i = PHYS - 1; i >= 0; i--) begin
        if (win[i]) begin
          issue_v_o   = 1'b1;
          issue_idx_o = IDX_W'(i);
        end
      end
    end
  end

  AST_FRONT_WAITING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    front_v_q |-> wait_vec_i[front_idx_q]); // R7
  AST_ONE_WINNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(win)); // R4
  AST_ISSUE_WAITING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_v_o |-> wait_vec_i[issue_idx_o]); // R5
endmodule

// File: rtl/mshr_match.sv
module mshr_match #(
  parameter int PHYS   = 4,
  parameter int IDX_W  = 2,
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              secure_i,
  input  logic [PHYS-1:0]   valid_vec_i,
  input  logic [PHYS-1:0]   wait_vec_i,
  input  logic [ADDR_W-1:0] ent_addr_i [PHYS],
  input  logic [PHYS-1:0]   ent_sec_i,
  output logic [PHYS-1:0]   match_vec_o,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              wait_hit_o
);
  always_comb begin
    for (int i = 0; i < PHYS; i++)
      match_vec_o[i] = valid_vec_i[i] && ent_addr_i[i] == addr_i && ent_sec_i[i] == secure_i;
    hit_o      = |match_vec_o;
    wait_hit_o = |(match_vec_o & wait_vec_i);
    idx_o      = '0;
    for (int i = PHYS - 1; i >= 0; i--) begin
      if (match_vec_o[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int NUM_RESERVE = 1,
  parameter int ADDR_W      = 16,
  parameter int TID_W       = 2,
  parameter int TIME_W      = 8,
  localparam int PHYS       = NUM_ENTRIES + NUM_RESERVE - 1,
  localparam int IDX_W      = (PHYS > 1) ? $clog2(PHYS) : 1,
  localparam int CNT_W      = $clog2(PHYS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] now_i,
  input  logic              alloc_valid_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic              alloc_secure_i,
  input  logic [TID_W-1:0]  alloc_tid_i,
  input  logic [TIME_W-1:0] alloc_ready_i,
  output logic [IDX_W-1:0]  alloc_idx_o,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  input  logic              lookup_secure_i,
  output logic              lookup_hit_o,
  output logic [IDX_W-1:0]  lookup_idx_o,
  output logic [PHYS-1:0]   lookup_vec_o,
  output logic              lookup_wait_hit_o,
  output logic              issue_valid_o,
  output logic [IDX_W-1:0]  issue_idx_o,
  input  logic              svc_valid_i,
  input  logic [IDX_W-1:0]  svc_idx_i,
  input  logic              pend_valid_i,
  input  logic [IDX_W-1:0]  pend_idx_i,
  input  logic              front_valid_i,
  input  logic [IDX_W-1:0]  front_idx_i,
  input  logic              free_valid_i,
  input  logic [IDX_W-1:0]  free_idx_i,
  input  logic              squash_valid_i,
  input  logic [TID_W-1:0]  squash_tid_i,
  input  logic              drain_req_i,
  output logic              drain_done_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [CNT_W-1:0]  alloc_count_o,
  output logic [CNT_W-1:0]  svc_count_o,
  output logic              err_o
);
  ent_state_e        st_q   [PHYS];
  logic [ADDR_W-1:0] addr_q [PHYS];
  logic [TID_W-1:0]  tid_q  [PHYS];
  logic [TIME_W-1:0] rt_q   [PHYS];
  logic [PHYS-1:0]   sec_q;

  logic [PHYS-1:0]   valid_vec, wait_vec, svc_vec;
  logic [PHYS-1:0]   freed_vec, ins_vec, leave_vec;
  logic [CNT_W-1:0]  alloc_cnt_q, svc_cnt_q, alloc_cnt_d, svc_cnt_d, freed_cnt;
  logic              drain_pend_q, drain_done_q, drain_pend_d, drain_done_d;
  logic              err_q, err_ev;
  logic              pick_v;
  logic [IDX_W-1:0]  pick_idx;
  cmd_e              cmd;

  function automatic logic idx_ok(logic [IDX_W-1:0] idx);
    return int'(idx) < PHYS;
  endfunction

  always_comb begin
    for (int i = 0; i < PHYS; i++) begin
      valid_vec[i] = st_q[i] != ENT_FREE;
      wait_vec[i]  = st_q[i] == ENT_WAIT;
      svc_vec[i]   = st_q[i] == ENT_SVC;
    end
  end

  // one command per cycle, fixed priority
  always_comb begin
    cmd    = CMD_NONE;
    err_ev = 1'b0;
    if (squash_valid_i) begin
      cmd = CMD_SQUASH;
    end else if (free_valid_i) begin
      if (idx_ok(free_idx_i) && valid_vec[free_idx_i]) cmd = CMD_FREE;
      else err_ev = 1'b1;
    end else if (svc_valid_i) begin
      if (idx_ok(svc_idx_i) && wait_vec[svc_idx_i]) cmd = CMD_SVC;
      else err_ev = 1'b1;
    end else if (pend_valid_i) begin
      if (idx_ok(pend_idx_i) && svc_vec[pend_idx_i]) cmd = CMD_PEND;
      else err_ev = 1'b1;
    end else if (front_valid_i) begin
      if (!idx_ok(front_idx_i) || !valid_vec[front_idx_i]) err_ev = 1'b1;
      else if (wait_vec[front_idx_i]) cmd = CMD_FRONT;
    end else if (alloc_valid_i) begin
      if (pick_v) cmd = CMD_ALLOC;
      else err_ev = 1'b1;
    end
  end

  always_comb begin
    freed_cnt = '0;
    for (int i = 0; i < PHYS; i++) begin
      freed_vec[i] = (cmd == CMD_SQUASH && wait_vec[i] && tid_q[i] == squash_tid_i)
                  || (cmd == CMD_FREE && free_idx_i == IDX_W'(i));
      ins_vec[i]   = (cmd == CMD_ALLOC && pick_idx == IDX_W'(i))
                  || (cmd == CMD_PEND && pend_idx_i == IDX_W'(i));
      leave_vec[i] = freed_vec[i] || (cmd == CMD_SVC && svc_idx_i == IDX_W'(i));
      freed_cnt    = freed_cnt + CNT_W'(freed_vec[i]);
    end
  end

  always_comb begin
    alloc_cnt_d = alloc_cnt_q - freed_cnt + CNT_W'(cmd == CMD_ALLOC);
    svc_cnt_d   = svc_cnt_q;
    if (cmd == CMD_SVC) svc_cnt_d = svc_cnt_q + 1'b1;
    if (cmd == CMD_PEND) svc_cnt_d = svc_cnt_q - 1'b1;
    if (cmd == CMD_FREE && svc_vec[free_idx_i]) svc_cnt_d = svc_cnt_q - 1'b1;
    drain_done_d = (drain_req_i && alloc_cnt_q == '0)
                || ((drain_req_i || drain_pend_q) && alloc_cnt_d == '0);
    drain_pend_d = (drain_req_i || drain_pend_q) && !drain_done_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PHYS; i++) begin
        st_q[i]   <= ENT_FREE;
        addr_q[i] <= '0;
        tid_q[i]  <= '0;
        rt_q[i]   <= '0;
      end
      sec_q <= '0;
    end else begin
      for (int i = 0; i < PHYS; i++) begin
        if (freed_vec[i]) begin
          st_q[i] <= ENT_FREE;
        end else if (ins_vec[i]) begin
          st_q[i] <= ENT_WAIT;
          if (cmd == CMD_ALLOC) begin
            addr_q[i] <= alloc_addr_i;
            sec_q[i]  <= alloc_secure_i;
            tid_q[i]  <= alloc_tid_i;
            rt_q[i]   <= alloc_ready_i;
          end
        end else if (leave_vec[i]) begin
          st_q[i] <= ENT_SVC;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alloc_cnt_q  <= '0;
      svc_cnt_q    <= '0;
      drain_pend_q <= 1'b0;
      drain_done_q <= 1'b0;
      err_q        <= 1'b0;
    end else begin
      alloc_cnt_q  <= alloc_cnt_d;
      svc_cnt_q    <= svc_cnt_d;
      drain_pend_q <= drain_pend_d;
      drain_done_q <= drain_done_d;
      err_q        <= err_q | err_ev;
    end
  end

  mshr_free_pick #(.PHYS(PHYS), .IDX_W(IDX_W)) u_free (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .free_vec_i  (~valid_vec),
    .freed_vec_i (freed_vec),
    .pick_v_o    (pick_v),
    .pick_idx_o  (pick_idx)
  );

  mshr_issue_sel #(.PHYS(PHYS), .IDX_W(IDX_W), .TIME_W(TIME_W)) u_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .now_i       (now_i),
    .wait_vec_i  (wait_vec),
    .rt_i        (rt_q),
    .ins_vec_i   (ins_vec),
    .leave_vec_i (leave_vec),
    .front_set_i (cmd == CMD_FRONT),
    .front_idx_i (front_idx_i),
    .issue_v_o   (issue_valid_o),
    .issue_idx_o (issue_idx_o)
  );

  mshr_match #(.PHYS(PHYS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_match (
    .addr_i      (lookup_addr_i),
    .secure_i    (lookup_secure_i),
    .valid_vec_i (valid_vec),
    .wait_vec_i  (wait_vec),
    .ent_addr_i  (addr_q),
    .ent_sec_i   (sec_q),
    .match_vec_o (lookup_vec_o),
    .hit_o       (lookup_hit_o),
    .idx_o       (lookup_idx_o),
    .wait_hit_o  (lookup_wait_hit_o)
  );

  assign alloc_idx_o   = pick_idx;
  assign full_o        = alloc_cnt_q == CNT_W'(PHYS);
  assign empty_o       = alloc_cnt_q == '0;
  assign alloc_count_o = alloc_cnt_q;
  assign svc_count_o   = svc_cnt_q;
  assign drain_done_o  = drain_done_q;
  assign err_o         = err_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_cnt_q <= CNT_W'(PHYS)); // R1
  AST_CNT_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(alloc_cnt_q) == $countones(valid_vec)); // R8
  AST_SVC_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(svc_cnt_q) == $countones(svc_vec)); // R5
  AST_FULL_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_ALLOC) |-> !full_o); // R11
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R11
  AST_DRAIN_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_done_o |-> empty_o); // R10
  AST_SQUASH_KEEPS_SVC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_SQUASH) |=> svc_cnt_q == $past(svc_cnt_q)); // R9
endmodule

// File: tb/mshr_file_test.sv
module mshr_file_test;
  localparam int CLK_PERIOD = 10;
  localparam int PHYS = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  now_i = '0;
  logic        alloc_valid_i = 1'b0;
  logic [15:0] alloc_addr_i = '0;
  logic        alloc_secure_i = 1'b0;
  logic [1:0]  alloc_tid_i = '0;
  logic [7:0]  alloc_ready_i = '0;
  logic [1:0]  alloc_idx_o;
  logic [15:0] lookup_addr_i = '0;
  logic        lookup_secure_i = 1'b0;
  logic        lookup_hit_o;
  logic [1:0]  lookup_idx_o;
  logic [3:0]  lookup_vec_o;
  logic        lookup_wait_hit_o;
  logic        issue_valid_o;
  logic [1:0]  issue_idx_o;
  logic        svc_valid_i = 1'b0;
  logic [1:0]  svc_idx_i = '0;
  logic        pend_valid_i = 1'b0;
  logic [1:0]  pend_idx_i = '0;
  logic        front_valid_i = 1'b0;
  logic [1:0]  front_idx_i = '0;
  logic        free_valid_i = 1'b0;
  logic [1:0]  free_idx_i = '0;
  logic        squash_valid_i = 1'b0;
  logic [1:0]  squash_tid_i = '0;
  logic        drain_req_i = 1'b0;
  logic        drain_done_o, full_o, empty_o, err_o;
  logic [2:0]  alloc_count_o, svc_count_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  mshr_file uut (.*);

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  // {addr, secure, tid, ready, expected index}
  localparam logic [28:0] ALLOC_TBL [4] = '{
    {16'h0100, 1'b0, 2'd0, 8'd5, 2'd0},
    {16'h0200, 1'b1, 2'd1, 8'd3, 2'd1},
    {16'h0100, 1'b1, 2'd0, 8'd3, 2'd2},
    {16'h0100, 1'b0, 2'd1, 8'd5, 2'd3}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic clear_in();
    alloc_valid_i = 0; svc_valid_i = 0; pend_valid_i = 0; front_valid_i = 0;
    free_valid_i = 0; squash_valid_i = 0; drain_req_i = 0;
  endtask

  task automatic do_alloc(logic [15:0] a, logic s, logic [1:0] t, logic [7:0] r);
    alloc_valid_i = 1; alloc_addr_i = a; alloc_secure_i = s; alloc_tid_i = t; alloc_ready_i = r;
    tick(); clear_in();
  endtask

  task automatic do_svc(logic [1:0] i);   svc_valid_i = 1; svc_idx_i = i; tick(); clear_in(); endtask
  task automatic do_pend(logic [1:0] i);  pend_valid_i = 1; pend_idx_i = i; tick(); clear_in(); endtask
  task automatic do_front(logic [1:0] i); front_valid_i = 1; front_idx_i = i; tick(); clear_in(); endtask
  task automatic do_free(logic [1:0] i);  free_valid_i = 1; free_idx_i = i; tick(); clear_in(); endtask
  task automatic do_squash(logic [1:0] t); squash_valid_i = 1; squash_tid_i = t; tick(); clear_in(); endtask

  task automatic look(logic [15:0] a, logic s);
    lookup_addr_i = a; lookup_secure_i = s; #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    // reset state
    check("R1 reset empty", empty_o, 1);
    check("R1 reset full", full_o, 0);
    check("R1 reset count", alloc_count_o, 0);
    check("R11 reset err", err_o, 0);
    check("R4 reset issue", issue_valid_o, 0);
    check("R2 reset pick", alloc_idx_o, 0);

    // table of allocations
    for (int k = 0; k < 4; k++) begin
      check("R2 alloc index", alloc_idx_o, ALLOC_TBL[k][1:0]);
      do_alloc(ALLOC_TBL[k][28:13], ALLOC_TBL[k][12], ALLOC_TBL[k][11:10], ALLOC_TBL[k][9:2]);
      check("R1 alloc count", alloc_count_o, k + 1);
    end
    check("R1 full", full_o, 1);
    check("R1 not empty", empty_o, 0);

    // lookups
    look(16'h0100, 0);
    check("R3 hit a", lookup_hit_o, 1);
    check("R3 first idx a", lookup_idx_o, 0);
    check("R3 vec a", lookup_vec_o, 4'b1001);
    look(16'h0100, 1);
    check("R3 secure differs", lookup_vec_o, 4'b0100);
    check("R3 idx secure", lookup_idx_o, 2);
    look(16'h0300, 0);
    check("R3 miss", lookup_hit_o, 0);

    // issue ordering
    now_i = 8'd2; #1;
    check("R4 none eligible", issue_valid_o, 0);
    now_i = 8'd3; #1;
    check("R4 tie older wins", issue_idx_o, 1);
    now_i = 8'd10; #1;
    check("R4 smallest ready", issue_idx_o, 1);

    do_svc(1);
    check("R5 svc count", svc_count_o, 1);
    check("R5 still held", alloc_count_o, 4);
    check("R5 issue skips svc", issue_idx_o, 2);
    look(16'h0200, 1);
    check("R3 hit svc entry", lookup_hit_o, 1);
    check("R3 wait-only miss", lookup_wait_hit_o, 0);

    // front override
    now_i = 8'd0;
    do_front(3);
    check("R7 front valid", issue_valid_o, 1);
    check("R7 front idx", issue_idx_o, 3);
    do_front(1);
    check("R7 front on svc ignored", issue_idx_o, 3);
    check("R7 no err", err_o, 0);

    now_i = 8'd10;
    do_pend(1);
    check("R6 svc count down", svc_count_o, 0);
    check("R7 front kept", issue_idx_o, 3);
    do_svc(3);
    check("R6 reinserted as newest", issue_idx_o, 2);
    check("R5 svc count", svc_count_o, 1);

    // frees and reuse order
    do_free(2);
    check("R8 count after free", alloc_count_o, 3);
    check("R8 full clears", full_o, 0);
    check("R2 reuse freed", alloc_idx_o, 2);
    do_free(3);
    check("R8 svc count on free", svc_count_o, 0);
    check("R8 count", alloc_count_o, 2);
    check("R2 most recent freed", alloc_idx_o, 3);

    // squash
    do_svc(0);
    do_squash(0);
    check("R9 svc kept", alloc_count_o, 2);
    check("R9 svc count", svc_count_o, 1);
    do_squash(1);
    check("R9 waiting freed", alloc_count_o, 1);
    check("R2 squashed slot reused", alloc_idx_o, 1);
    look(16'h0100, 0);
    check("R3 vec after squash", lookup_vec_o, 4'b0001);
    check("R3 wait-only svc", lookup_wait_hit_o, 0);

    // drain
    drain_req_i = 1; tick(); clear_in();
    check("R10 not done while held", drain_done_o, 0);
    tick();
    check("R10 still pending", drain_done_o, 0);
    do_free(0);
    check("R10 done on last free", drain_done_o, 1);
    check("R1 empty", empty_o, 1);
    tick();
    check("R10 pulse ends", drain_done_o, 0);
    drain_req_i = 1; tick(); clear_in();
    check("R10 done on empty", drain_done_o, 1);
    check("R11 no err yet", err_o, 0);

    // priority
    check("R2 pick after frees", alloc_idx_o, 0);
    do_alloc(16'h0500, 0, 2, 1);
    free_valid_i = 1; free_idx_i = 0;
    alloc_valid_i = 1; alloc_addr_i = 16'h0600;
    tick(); clear_in();
    check("R12 free beats alloc", alloc_count_o, 0);
    look(16'h0600, 0);
    check("R12 alloc dropped", lookup_hit_o, 0);

    // errors
    do_pend(2);
    check("R11 pend on free err", err_o, 1);
    check("R11 state kept", alloc_count_o, 0);
    for (int k = 0; k < 4; k++) do_alloc(16'h0700 + 16'(k), 0, 0, 0);
    do_alloc(16'h0800, 0, 0, 0);
    check("R11 full alloc count", alloc_count_o, 4);
    look(16'h0800, 0);
    check("R11 full alloc dropped", lookup_hit_o, 0);
    check("R11 err sticky", err_o, 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule